// File: doc/BRIEF.md
# Multi-Bank Flash Command Front-End

This block is a synthesizable behavioural model of the control side of a banked NOR-style flash with a 16-bit word bus. It turns the active-low chip-enable, output-enable and write-enable strobes into read, write and standby cycles. It sends bits 22..20 of the word address to one of four banks, which are decoded unevenly. It recognises the command sequences written on the bus. Each bank has its own busy timer, so one bank can run an embedded program while reads to the other three banks return array data in the same access.

A small command state machine has four states. `ST_IDLE` waits for a command. `ST_UNLK1` has seen the first unlock write. `ST_UNLK2` has seen the second unlock write. `ST_PGM_DATA` waits for the program address and data.

The transitions are as follows:
- `ST_IDLE` goes to `ST_UNLK1` on data 0xAA at 0x555.
- `ST_IDLE` goes to `ST_PGM_DATA` on 0xA0 when bypass is in effect.
- `ST_UNLK1` goes to `ST_UNLK2` on 0x55 at 0x2AA.
- `ST_UNLK2` goes to `ST_PGM_DATA` on 0xA0. On 0x20 it sets the bypass flag, on 0x90 it sets the autoselect flag, and on 0xF0 it clears both flags. After any of these three it returns to `ST_IDLE`.
- `ST_PGM_DATA` goes to `ST_IDLE` on any write, and that write launches the program.
- Every other write returns the machine to `ST_IDLE`.
- 0xF0 written in `ST_IDLE` clears both flags.

The memory is a register array with 2**OFFS_W words per bank, and every word resets to 0xFFFF.

Top module: `flash_cmd_frontend`

## Requirements
- R1: Address bits 22..20 pick the bank: 000 gives bank A (0); 001, 010 and 011 give bank B (1); 100, 101 and 110 give bank C (2); 111 gives bank D (3). The word inside a bank is address bits OFFS_W-1..0.
- R2: A read is `ce_n`=0, `oe_n`=0 and `we_n`=1. In a read, `dq_drive` is 1 and `dq_out` carries the addressed word in the same cycle. This holds even while another bank is busy.
- R3: With the upper address bits held, address bits 2..0 select word 0..7 of a page. Changing only those bits in a held read returns the new word in the same cycle.
- R4: A bus write is taken only in a cycle with `ce_n`=0, `we_n`=0 and `oe_n`=1. Strobes with `oe_n`=0 neither advance a sequence nor change the array.
- R5: Commands are decoded from `din[7:0]`, and unlock addresses are compared on `addr[10:0]`. The standard program is four writes: 0xAA@0x555, 0x55@0x2AA, 0xA0, then the target address and data. The stored word becomes the old word AND the data.
- R6: Writing 0xAA@0x555, 0x55@0x2AA, 0x20 enters unlock bypass. In bypass, the two writes 0xA0 and then address/data program a word. Writing 0xF0 in `ST_IDLE` leaves bypass.
- R7: A bank whose bit is set in PROT_MASK (default: bank D only) ignores program requests. While `accel`=1, bypass is in effect and protection is lifted. When `accel` returns to 0, both revert.
- R8: Writing 0xAA@0x555, 0x55@0x2AA, 0x90 enters autoselect. Reads to a non-busy bank then return MFR_ID (0x0001) for `addr[1:0]`=00, DEV_ID (0x227E) for 01, and 0x0000 otherwise. Writing 0xF0 returns reads to the array.
- R9: With `ce_n`=1, or while reset is asserted, `dq_drive` is 0 whatever `oe_n` is.
- R10: A program makes its bank busy for BUSY_CYCLES clocks (default 16), starting with the clock that takes the data write. A read of a busy bank returns BUSY_STATUS (0x0080).
- R11: A program aimed at a bank that is still busy is dropped, and that word keeps its value.
- R12: Any write that does not fit the current state returns the machine to `ST_IDLE`.
- R13: After reset, every array word reads 0xFFFF, no bank is busy, and bypass and autoselect are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| accel | input | 1 | Accelerated-program request |
| addr | input | ADDR_W (23) | Word address |
| din | input | WORD_W (16) | Write data |
| dq_out | output | WORD_W (16) | Read data |
| dq_drive | output | 1 | Data bus drive enable; 0 means high impedance |

## Verification
The hardest situation to reach from the ports is two banks active at once. One bank must be inside its busy window while a read goes to a different bank, and a second program must target the busy bank before its timer expires. The stimulus reaches this by issuing a program and following it at once with reads to aliased addresses of the same bank and to other banks. It then starts a back-to-back standard sequence on the busy bank, whose data write lands well inside the busy window. A behavioural reference model in the bench predicts the data bus on every clock, so each of these overlapping cycles is compared.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

    typedef enum logic [1:0] {
        BANK_A = 2'd0,
        BANK_B = 2'd1,
        BANK_C = 2'd2,
        BANK_D = 2'd3
    } bank_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_UNLK1,
        ST_UNLK2,
        ST_PGM_DATA
    } cmd_state_e;

    localparam logic [7:0]  CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0]  CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0]  CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0]  CMD_BYPASS   = 8'h20;
    localparam logic [7:0]  CMD_AUTOSEL  = 8'h90;
    localparam logic [7:0]  CMD_RESET    = 8'hF0;
    localparam logic [10:0] UNLK_ADDR_A  = 11'h555;
    localparam logic [10:0] UNLK_ADDR_B  = 11'h2AA;

    // Uneven decode: single codes at both ends, three codes for each middle bank.
    function automatic bank_e bank_of(input logic [2:0] hi);
        if (hi == 3'b000)      return BANK_A;
        else if (hi == 3'b111) return BANK_D;
        else if (hi[2])        return BANK_C;
        else                   return BANK_B;
    endfunction

endpackage

// File: rtl/fe_bank_timer.sv
module fe_bank_timer #(
    parameter int BUSY_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= CNT_W'(BUSY_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o = (cnt_q != '0);

    p_busy_from_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    p_count_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

    p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

endmodule

// File: rtl/fe_cmd_fsm.sv
module fe_cmd_fsm
    import flash_fe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [10:0] addr_i,
    input  logic [7:0]  data_i,
    input  logic        accel_i,
    output logic        prog_req_o,
    output logic        autosel_o
);
    cmd_state_e state_q, state_d;
    logic byp_q, as_q;
    logic byp_set, byp_clr, as_set, as_clr;
    logic byp_eff;

    assign byp_eff = byp_q | accel_i;

    // State register and mode flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            byp_q   <= 1'b0;
            as_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (byp_clr)      byp_q <= 1'b0;
            else if (byp_set) byp_q <= 1'b1;
            if (as_clr)       as_q  <= 1'b0;
            else if (as_set)  as_q  <= 1'b1;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        byp_set    = 1'b0;
        byp_clr    = 1'b0;
        as_set     = 1'b0;
        as_clr     = 1'b0;
        prog_req_o = 1'b0;
        if (wr_i) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (data_i == CMD_UNLOCK_A && addr_i == UNLK_ADDR_A) begin
                        state_d = ST_UNLK1;
                    end else if (byp_eff && data_i == CMD_PROGRAM) begin
                        state_d = ST_PGM_DATA;
                    end else if (data_i == CMD_RESET) begin
                        byp_clr = 1'b1;
                        as_clr  = 1'b1;
                    end
                end
                ST_UNLK1: begin
                    if (data_i == CMD_UNLOCK_B && addr_i == UNLK_ADDR_B)
                        state_d = ST_UNLK2;
                    else
                        state_d = ST_IDLE;
                end
                ST_UNLK2: begin
                    state_d = ST_IDLE;
                    if (data_i == CMD_PROGRAM) begin
                        state_d = ST_PGM_DATA;
                    end else if (data_i == CMD_BYPASS) begin
                        byp_set = 1'b1;
                    end else if (data_i == CMD_AUTOSEL) begin
                        as_set = 1'b1;
                    end else if (data_i == CMD_RESET) begin
                        byp_clr = 1'b1;
                        as_clr  = 1'b1;
                    end
                end
                ST_PGM_DATA: begin
                    state_d    = ST_IDLE;
                    prog_req_o = 1'b1;
                end
            endcase
        end
    end

    assign autosel_o = as_q;

    p_write_only_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> (state_q == $past(state_q)));

    p_prog_ends_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req_o |=> (state_q == ST_IDLE));

endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
    import flash_fe_pkg::*;
#(
    parameter int          WORD_W      = 16,
    parameter int          ADDR_W      = 23,
    parameter int          OFFS_W      = 4,
    parameter int          BUSY_CYCLES = 16,
    parameter logic [15:0] BUSY_STATUS = 16'h0080,
    parameter logic [15:0] MFR_ID      = 16'h0001,
    parameter logic [15:0] DEV_ID      = 16'h227E,
    parameter logic [3:0]  PROT_MASK   = 4'b1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              accel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_drive
);
    localparam int NBANK = 4;
    localparam int IDX_W = 2 + OFFS_W;
    localparam int DEPTH = NBANK << OFFS_W;

    logic              wr_cyc, rd_cyc;
    bank_e             bank_sel;
    logic [IDX_W-1:0]  idx;
    logic [NBANK-1:0]  busy;
    logic              prog_req, prog_go, autosel;
    logic              unused_addr_bits;
    logic [WORD_W-1:0] mem [DEPTH];

    assign wr_cyc   = !ce_n && !we_n && oe_n;
    assign rd_cyc   = !ce_n && !oe_n && we_n;
    assign bank_sel = bank_of(addr[ADDR_W-1 -: 3]);
    assign idx      = {bank_sel, addr[OFFS_W-1:0]};
    assign unused_addr_bits = ^addr[ADDR_W-4:11];

    fe_cmd_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_cyc),
        .addr_i     (addr[10:0]),
        .data_i     (din[7:0]),
        .accel_i    (accel),
        .prog_req_o (prog_req),
        .autosel_o  (autosel)
    );

    assign prog_go = prog_req && !busy[bank_sel] && (!PROT_MASK[bank_sel] || accel);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        fe_bank_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (prog_go && (bank_sel == bank_e'(b))),
            .busy_o  (busy[b])
        );
    end

    // Array: program can only clear bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (prog_go) begin
            mem[idx] <= mem[idx] & din;
        end
    end

    // Read path, zero latency
    always_comb begin
        dq_drive = rst_n && rd_cyc;
        if (busy[bank_sel]) begin
            dq_out = BUSY_STATUS;
        end else if (autosel) begin
            unique case (addr[1:0])
                2'b00:   dq_out = MFR_ID;
                2'b01:   dq_out = DEV_ID;
                default: dq_out = '0;
            endcase
        end else begin
            dq_out = mem[idx];
        end
    end

    p_standby_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !dq_drive);

    p_busy_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cyc && busy[bank_sel]) |-> (dq_out == BUSY_STATUS));

    p_protect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!accel && PROT_MASK[bank_sel]) |=> $stable(busy[bank_sel]) || !busy[bank_sel]);

endmodule

// File: tb/flash_cmd_frontend_test.sv
module flash_cmd_frontend_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, accel = 1'b0;
    logic [22:0] addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dq_out;
    logic        dq_drive;

    int total = 0;
    int failed = 0;
    bit done = 0;

    always #2 clk = ~clk;

    flash_cmd_frontend uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .accel(accel), .addr(addr), .din(din), .dq_out(dq_out), .dq_drive(dq_drive)
    );

    // ---------------- behavioural reference model ----------------
    int          m_st;           // 0 idle, 1 first unlock, 2 second unlock, 3 await data
    bit          m_byp, m_as;
    logic [15:0] m_arr [64];
    int          m_cnt [4];

    function automatic int bank_num(input logic [2:0] h);
        if (h == 3'd0) return 0;
        if (h == 3'd7) return 3;
        if (h >= 3'd4) return 2;
        return 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_byp = 0; m_as = 0;
            for (int i = 0; i < 64; i++) m_arr[i] = 16'hFFFF;
            for (int b = 0; b < 4; b++) m_cnt[b] = 0;
        end else begin
            int  bk, ix, go;
            bit  w;
            w  = !ce_n && !we_n && oe_n;
            bk = bank_num(addr[22:20]);
            ix = bk * 16 + int'(addr[3:0]);
            go = -1;
            if (w) begin
                case (m_st)
                    0: if (din[7:0] == 8'hAA && addr[10:0] == 11'h555) m_st = 1;
                       else if ((m_byp || accel) && din[7:0] == 8'hA0) m_st = 3;
                       else if (din[7:0] == 8'hF0) begin m_byp = 0; m_as = 0; end
                    1: m_st = (din[7:0] == 8'h55 && addr[10:0] == 11'h2AA) ? 2 : 0;
                    2: begin
                        m_st = 0;
                        if (din[7:0] == 8'hA0) m_st = 3;
                        else if (din[7:0] == 8'h20) m_byp = 1;
                        else if (din[7:0] == 8'h90) m_as = 1;
                        else if (din[7:0] == 8'hF0) begin m_byp = 0; m_as = 0; end
                    end
                    default: begin
                        m_st = 0;
                        if (m_cnt[bk] == 0 && (bk != 3 || accel)) begin
                            m_arr[ix] = m_arr[ix] & din;
                            go = bk;
                        end
                    end
                endcase
            end
            for (int b = 0; b < 4; b++) begin
                if (b == go) m_cnt[b] = 16;
                else if (m_cnt[b] > 0) m_cnt[b] = m_cnt[b] - 1;
            end
        end
    end

    // every-clock comparison against the model (R2 R9 R10)
    always @(negedge clk) begin
        #1;
        if (!done) begin
            bit          e_drv;
            logic [15:0] e_dat;
            int          bk;
            bk    = bank_num(addr[22:20]);
            e_drv = rst_n && !ce_n && !oe_n && we_n;
            if (m_cnt[bk] > 0) e_dat = 16'h0080;
            else if (m_as) e_dat = (addr[1:0] == 2'b00) ? 16'h0001 :
                                   (addr[1:0] == 2'b01) ? 16'h227E : 16'h0000;
            else e_dat = m_arr[bk * 16 + int'(addr[3:0])];
            total++;
            if (dq_drive !== e_drv || (e_drv && dq_out !== e_dat)) begin
                failed++;
                $display("FAIL R2 R10 model compare: got drive=%b data=%h expected drive=%b data=%h",
                         dq_drive, dq_out, e_drv, e_dat);
            end
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [22:0] fa(input logic [2:0] bk, input int off);
        logic [3:0] o;
        o = off[3:0];
        return {bk, 16'h0000, o};
    endfunction

    task automatic check(input string tag, input bit ok, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [22:0] a, input logic [15:0] d);
        @(negedge clk);
        ce_n = 0; we_n = 0; oe_n = 1; addr = a; din = d;
        @(negedge clk);
        ce_n = 1; we_n = 1; oe_n = 1;
    endtask

    task automatic rd(input logic [22:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        ce_n = 0; oe_n = 0; we_n = 1; addr = a;
        #1;
        check(tag, dq_drive === 1'b1 && dq_out === exp, dq_out, exp);
        @(negedge clk);
        ce_n = 1; oe_n = 1;
    endtask

    task automatic prog_std(input logic [22:0] a, input logic [15:0] d);
        wr(23'h555, 16'h00AA);
        wr(23'h2AA, 16'h0055);
        wr(23'h555, 16'h00A0);
        wr(a, d);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            failed++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", total, failed);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(2);

        // R13 reset state
        rd(fa(3'b000, 0), 16'hFFFF, "R13 reset array");
        rd(fa(3'b111, 15), 16'hFFFF, "R13 reset bank D");

        // R9 standby: ce high, oe low
        @(negedge clk); ce_n = 1; oe_n = 0; we_n = 1; #1;
        check("R9 standby drive", dq_drive === 1'b0, {15'b0, dq_drive}, 16'h0000);
        @(negedge clk); oe_n = 1;

        // R5 standard program and R10 busy, R2 simultaneous read
        prog_std(fa(3'b100, 5), 16'h1234);
        rd(fa(3'b101, 5), 16'h0080, "R10 busy status bank C");
        rd(fa(3'b000, 0), 16'hFFFF, "R2 read bank A during C busy");
        idle(18);
        rd(fa(3'b100, 5), 16'h1234, "R5 program result");
        prog_std(fa(3'b110, 5), 16'hFF00);
        idle(18);
        rd(fa(3'b100, 5), 16'h1200, "R5 AND semantics");

        // R1 bank decode
        prog_std(fa(3'b010, 2), 16'h00F0);
        rd(fa(3'b011, 2), 16'h0080, "R1 code 011 is bank B");
        rd(fa(3'b001, 7), 16'h0080, "R1 code 001 is bank B");
        rd(fa(3'b100, 1), 16'hFFFF, "R1 code 100 not bank B");
        idle(18);
        rd(fa(3'b001, 2), 16'h00F0, "R1 aliased bank B data");

        // R7 protected bank D without accel
        prog_std(fa(3'b111, 1), 16'h0000);
        rd(fa(3'b111, 1), 16'hFFFF, "R7 protected bank ignored");

        // R11 program to busy bank dropped
        prog_std(fa(3'b001, 3), 16'h0F0F);
        prog_std(fa(3'b001, 4), 16'h0000);
        idle(20);
        rd(fa(3'b001, 4), 16'hFFFF, "R11 busy program dropped");
        rd(fa(3'b001, 3), 16'h0F0F, "R11 first program kept");

        // R6 unlock bypass
        wr(23'h555, 16'h00AA); wr(23'h2AA, 16'h0055); wr(23'h555, 16'h0020);
        wr(23'h000, 16'h00A0); wr(fa(3'b000, 6), 16'h5555);
        idle(18);
        rd(fa(3'b000, 6), 16'h5555, "R6 two-cycle program");
        wr(23'h000, 16'h00F0);
        wr(23'h000, 16'h00A0); wr(fa(3'b000, 7), 16'h0000);
        idle(18);
        rd(fa(3'b000, 7), 16'hFFFF, "R6 bypass exited by F0");

        // R7 accelerate
        accel = 1;
        wr(23'h000, 16'h00A0); wr(fa(3'b111, 1), 16'h00FF);
        idle(18);
        rd(fa(3'b111, 1), 16'h00FF, "R7 accel programs protected bank");
        accel = 0;
        wr(23'h000, 16'h00A0); wr(fa(3'b100, 0), 16'h0000);
        idle(18);
        rd(fa(3'b100, 0), 16'hFFFF, "R7 accel released");

        // R8 autoselect
        wr(23'h555, 16'h00AA); wr(23'h2AA, 16'h0055); wr(23'h555, 16'h0090);
        rd(fa(3'b000, 0), 16'h0001, "R8 manufacturer id");
        rd(fa(3'b000, 1), 16'h227E, "R8 device id");
        rd(fa(3'b000, 2), 16'h0000, "R8 other id");
        wr(23'h000, 16'h00F0);
        rd(fa(3'b000, 6), 16'h5555, "R8 back to array");

        // R12 out-of-sequence write returns idle
        wr(23'h555, 16'h00AA); wr(23'h2AA, 16'h0011);
        wr(23'h2AA, 16'h0055); wr(23'h555, 16'h00A0); wr(fa(3'b000, 3), 16'h0000);
        idle(18);
        rd(fa(3'b000, 3), 16'hFFFF, "R12 broken sequence ignored");

        // R4 write strobes with oe low are not writes
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            ce_n = 0; we_n = 0; oe_n = 0;
            addr = (k == 0) ? 23'h555 : (k == 1) ? 23'h2AA : (k == 2) ? 23'h555 : fa(3'b000, 9);
            din  = (k == 0) ? 16'h00AA : (k == 1) ? 16'h0055 : (k == 2) ? 16'h00A0 : 16'h0000;
            @(negedge clk);
            ce_n = 1; we_n = 1; oe_n = 1;
        end
        rd(fa(3'b000, 9), 16'hFFFF, "R4 oe low blocks write");

        // R3 page mode
        accel = 1;
        for (int i = 0; i < 8; i++) begin
            wr(23'h000, 16'h00A0);
            wr(fa(3'b100, 8 + i), ~(16'h0001 << i));
            idle(18);
        end
        accel = 0;
        @(negedge clk);
        ce_n = 0; oe_n = 0; we_n = 1;
        for (int i = 0; i < 8; i++) begin
            addr = fa(3'b100, 8 + i);
            #1;
            check("R3 page word select", dq_drive === 1'b1 && dq_out === ~(16'h0001 << i),
                  dq_out, ~(16'h0001 << i));
            @(negedge clk);
        end
        ce_n = 1; oe_n = 1;

        // R9 ce low but oe high: no drive
        @(negedge clk); ce_n = 0; oe_n = 1; we_n = 1; #1;
        check("R9 oe high no drive", dq_drive === 1'b0, {15'b0, dq_drive}, 16'h0000);
        @(negedge clk); ce_n = 1;
        idle(2);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", total, failed);
        $finish;
    end

endmodule